// File: doc/BRIEF.md
# Slow-Clock Serial Receiver with Fractional Bit Timing

This block receives asynchronous serial frames while clocked from a slow real-time domain of 32768 Hz or 8192 Hz. An integer divider cannot hit common bit rates from such a clock. Bit timing instead comes from a 16-bit phase accumulator. Each clock it adds a programmable increment equal to 65536 × baud / f_clk, and every carry out of the top bit marks one sample point. The falling edge of a start bit reloads the accumulator to half scale. Each later bit is therefore sampled near its centre.

One of four input lines is chosen by a select field. The chosen line is synchronised and passed through a glitch filter whose depth is set by a select field. The receiver then reassembles 8- or 9-bit words, sent either least- or most-significant bit first, with an optional parity bit in one of five modes. Software uses a small register bus: a write strobe, an address, and a combinational read path. Through it, software configures the block, reads the last word, and clears sticky flags. An interrupt output is the OR of the flags whose enables are set. Two configuration bits (calibration off, wake mode) are stored and read back only.

Registers (address in `bus_addr_i`):
- 0 CONFIG:
  - [0] enable
  - [2:1] filter select (a change passes once it has held for 2^sel clocks)
  - [5:3] parity mode
  - [6] nine-bit word
  - [7] most-significant bit first
  - [9:8] line select
  - [10] interrupt enable for received
  - [11] interrupt enable for parity error
  - [12] interrupt enable for overrun
  - [13] calibration-off
  - [14] wake mode
- 1 STEP: the 16-bit increment.
- 2 FLAGS:
  - [0] received
  - [1] parity error
  - [2] overrun
  - a 1 written to a bit clears it
- 3 WORD: the last received word, read only.

Top module: `lcu_rx_top`

## Requirements
- R1: After reset CONFIG reads 0, STEP reads 0x4B00, FLAGS reads 0, WORD reads 0 and `irq_o` is low.
- R2: With STEP = s, the accumulator is loaded with 0x8000 at the start edge and adds s every clock; each carry is one sample point, and frames at bit periods of 65536/s clocks are received correctly for s = 0x0400, 0x0800 and 0x0C00.
- R3: CONFIG[6] = 0 takes 8 data bits (WORD[8] reads 0), CONFIG[6] = 1 takes 9 data bits.
- R4: CONFIG[7] = 0 treats the first data bit as bit 0; CONFIG[7] = 1 treats it as the top bit of the word.
- R5: Parity mode codes: 0 none, 1 even (data plus parity bit has an even count of ones), 2 odd, 3 parity bit must be 0, 4 parity bit must be 1; with parity enabled the bit after the data is compared and a mismatch sets FLAGS[1] along with FLAGS[0].
- R6: Only the line picked by CONFIG[9:8] is received; frames on other lines have no effect.
- R7: With filter select f, a level change on the selected line shorter than 2^f clocks is not seen by the receiver.
- R8: A start bit that reads high at its centre sample is discarded and no word is delivered.
- R9: A completed frame sets FLAGS[0] and loads WORD; writing 1 to a FLAGS bit clears that bit only, writing 0x7 clears all, and a completion in the same cycle as a clear wins.
- R10: A frame completing while FLAGS[0] is set sets FLAGS[2] and overwrites WORD.
- R11: `irq_o` equals the OR of FLAGS[i] AND CONFIG[10+i] over i = 0..2.
- R12: Clearing CONFIG[0] returns the receiver to idle and the line is ignored, including a frame in progress; STEP, WORD and FLAGS keep their values.
- R13: CONFIG bits 13 and 14 are stored and read back unchanged and do not alter reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_lines_i | input | 4 | Candidate serial input lines, idle high |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect at the next rising edge, and reads and `irq_o` follow the registers within the same cycle, so the bench reads one half-cycle after each write. A line change reaches the receiver 3 + (2^f − 1) clocks after it is driven. The sample for bit k falls at clock ceil((32768 + 65536·k)/s) after that, which sets the flags about half a bit before the frame's stop bit ends. The bench drives each frame clock by clock from the same arithmetic. It reads FLAGS and WORD two cycles after the last stop-bit clock, and it places filter glitches around the computed sample offset of a data bit.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  localparam logic [1:0] A_CFG   = 2'd0;
  localparam logic [1:0] A_STEP  = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;
  localparam logic [1:0] A_WORD  = 2'd3;

  localparam int CFG_W       = 15;
  localparam int CFG_EN      = 0;
  localparam int CFG_FLT_LO  = 1;
  localparam int CFG_PAR_LO  = 3;
  localparam int CFG_NINE    = 6;
  localparam int CFG_MSB     = 7;
  localparam int CFG_LINE_LO = 8;
  localparam int CFG_IE_LO   = 10;

  localparam int N_FLAGS = 3;
  localparam int FLG_RX  = 0;
  localparam int FLG_PE  = 1;
  localparam int FLG_OV  = 2;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ZERO = 3'd3,
    PAR_ONE  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;
endpackage

// File: rtl/lcu_line_filter.sv
module lcu_line_filter #(
  parameter int LINES       = 4,
  parameter int SEL_W       = $clog2(LINES),
  parameter int FLT_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [FLT_W-1:0] flt_i,
  output logic             line_o
);
  localparam int MAX_RUN = 1 << ((1 << FLT_W) - 1);
  localparam int CNT_W   = (MAX_RUN > 1) ? $clog2(MAX_RUN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sync_w;
  logic [CNT_W-1:0]       run_q;
  logic [CNT_W-1:0]       lim_w;

  assign sync_w = sync_q[SYNC_STAGES-1];
  assign lim_w  = CNT_W'((32'd1 << flt_i) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], lines_i[sel_i]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_o <= 1'b1;
      run_q  <= '0;
    end else if (sync_w == line_o) begin
      run_q <= '0;
    end else if (run_q == lim_w) begin
      line_o <= sync_w;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_w == line_o) |=> $stable(line_o)); // R7
endmodule

// File: rtl/lcu_bit_clock.sv
module lcu_bit_clock #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc_i,
  input  logic             load_i,
  input  logic             run_i,
  output logic             tick_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum_w;

  assign sum_w  = {1'b0, acc_q} + {1'b0, inc_i};
  assign tick_o = run_i & sum_w[ACC_W] & ~load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= '0;
    else if (load_i) acc_q <= HALF;
    else if (run_i)  acc_q <= sum_w[ACC_W-1:0];
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && inc_i <= HALF) |=> (!tick_o || !$stable(inc_i))); // R2
endmodule

// File: rtl/lcu_rx_frame.sv
module lcu_rx_frame
  import lcu_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          line_i,
  input  logic          tick_i,
  input  logic          nine_i,
  input  logic          msb_i,
  input  logic [2:0]    par_i,
  output logic          start_o,
  output logic          run_o,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o
);
  localparam int IDX_W = $clog2(DW);

  rx_state_e        st_q;
  logic             line_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    word_q;
  logic             par_q;
  logic [IDX_W-1:0] last_w;
  logic [IDX_W-1:0] pos_w;
  logic             has_par_w;
  logic             exp_par_w;

  assign last_w    = nine_i ? IDX_W'(DW - 1) : IDX_W'(DW - 2);
  assign pos_w     = msb_i ? (last_w - idx_q) : idx_q;
  assign has_par_w = (par_i != PAR_NONE) && (par_i <= PAR_ONE);

  always_comb begin
    case (par_mode_e'(par_i))
      PAR_EVEN: exp_par_w = ^word_q;
      PAR_ODD:  exp_par_w = ~^word_q;
      PAR_ONE:  exp_par_w = 1'b1;
      default:  exp_par_w = 1'b0;
    endcase
  end

  assign start_o = en_i && (st_q == ST_IDLE) && line_q && !line_i;
  assign run_o   = (st_q != ST_IDLE);
  assign done_o  = en_i && (st_q == ST_STOP) && tick_i;
  assign data_o  = word_q;
  assign perr_o  = has_par_w && (par_q != exp_par_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      line_q <= 1'b1;
      idx_q  <= '0;
      word_q <= '0;
      par_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      if (!en_i) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE:  if (start_o) st_q <= ST_START;
          ST_START: if (tick_i) begin
            if (line_i) st_q <= ST_IDLE;
            else begin
              st_q   <= ST_DATA;
              idx_q  <= '0;
              word_q <= '0;
              par_q  <= 1'b0;
            end
          end
          ST_DATA: if (tick_i) begin
            word_q[pos_w] <= line_i;
            if (idx_q == last_w) st_q <= has_par_w ? ST_PAR : ST_STOP;
            else idx_q <= idx_q + 1'b1;
          end
          ST_PAR: if (tick_i) begin
            par_q <= line_i;
            st_q  <= ST_STOP;
          end
          ST_STOP: if (tick_i) st_q <= ST_IDLE;
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == ST_IDLE)); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/lcu_rx_top.sv
module lcu_rx_top
  import lcu_pkg::*;
#(
  parameter int LINES       = 4,
  parameter int DW          = 9,
  parameter int ACC_W       = 16,
  parameter int FLT_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int BUS_W       = 16,
  parameter logic [ACC_W-1:0] STEP_RST = 16'h4B00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rx_lines_i,
  input  logic [1:0]       bus_addr_i,
  input  logic             bus_we_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  localparam int SEL_W = $clog2(LINES);

  logic [CFG_W-1:0]   cfg_q;
  logic [ACC_W-1:0]   step_q;
  logic [N_FLAGS-1:0] flags_q;
  logic [DW-1:0]      word_q;

  logic               en_w, nine_w, msb_w;
  logic [FLT_W-1:0]   flt_w;
  logic [2:0]         par_w;
  logic [SEL_W-1:0]   sel_w;
  logic [N_FLAGS-1:0] ie_w, clr_w, set_w;
  logic               line_w, tick_w, start_w, run_w, done_w, perr_w;
  logic [DW-1:0]      data_w;

  assign en_w   = cfg_q[CFG_EN];
  assign flt_w  = cfg_q[CFG_FLT_LO +: FLT_W];
  assign par_w  = cfg_q[CFG_PAR_LO +: 3];
  assign nine_w = cfg_q[CFG_NINE];
  assign msb_w  = cfg_q[CFG_MSB];
  assign sel_w  = cfg_q[CFG_LINE_LO +: SEL_W];
  assign ie_w   = cfg_q[CFG_IE_LO +: N_FLAGS];

  lcu_line_filter #(.LINES(LINES), .SEL_W(SEL_W), .FLT_W(FLT_W), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst_n(rst_n), .lines_i(rx_lines_i), .sel_i(sel_w), .flt_i(flt_w), .line_o(line_w));

  lcu_bit_clock #(.ACC_W(ACC_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .inc_i(step_q), .load_i(start_w), .run_i(run_w), .tick_o(tick_w));

  lcu_rx_frame #(.DW(DW)) u_frame (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .line_i(line_w), .tick_i(tick_w),
    .nine_i(nine_w), .msb_i(msb_w), .par_i(par_w), .start_o(start_w), .run_o(run_w),
    .done_o(done_w), .data_o(data_w), .perr_o(perr_w));

  assign clr_w = (bus_we_i && bus_addr_i == A_FLAGS) ? bus_wdata_i[N_FLAGS-1:0] : '0;

  always_comb begin
    set_w         = '0;
    set_w[FLG_RX] = done_w;
    set_w[FLG_PE] = done_w & perr_w;
    set_w[FLG_OV] = done_w & flags_q[FLG_RX];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      step_q  <= STEP_RST;
      flags_q <= '0;
      word_q  <= '0;
    end else begin
      if (bus_we_i && bus_addr_i == A_CFG)  cfg_q  <= bus_wdata_i[CFG_W-1:0];
      if (bus_we_i && bus_addr_i == A_STEP) step_q <= bus_wdata_i[ACC_W-1:0];
      flags_q <= (flags_q & ~clr_w) | set_w;
      if (done_w) word_q <= data_w;
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_CFG:   bus_rdata_o = BUS_W'(cfg_q);
      A_STEP:  bus_rdata_o = BUS_W'(step_q);
      A_FLAGS: bus_rdata_o = BUS_W'(flags_q);
      default: bus_rdata_o = BUS_W'(word_q);
    endcase
  end

  assign irq_o = |(flags_q & ie_w);

  AST_OV_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FLG_OV]) |-> $past(flags_q[FLG_RX])); // R10
  AST_RX_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> flags_q[FLG_RX]); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_w == '0) |-> !irq_o); // R11
  AST_REGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_i |=> ($stable(cfg_q) && $stable(step_q))); // R13
endmodule

// File: tb/tb_lcu_rx_top.sv
module tb_lcu_rx_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  lines = 4'hF;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  lcu_rx_top dut (
    .clk(clk), .rst_n(rst_n), .rx_lines_i(lines), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  function automatic logic [15:0] mk_cfg(int en, int flt, int par, int nine, int msb, int ln, int ie);
    return 16'(en | (flt << 1) | (par << 3) | (nine << 6) | (msb << 7) | (ln << 8) | (ie << 10));
  endfunction

  // gbit: frame bit index to glitch (start = 0), glitch covers clocks 12..18 of that bit
  task automatic send_frame(int ln, int val, int nine, int msb, int par, int bad, int inc, int gbit);
    int n, nb, ones, p, total;
    bit bits [12];
    n = nine ? 9 : 8;
    nb = 0;
    bits[nb] = 1'b0; nb++;
    for (int i = 0; i < n; i++) begin
      bits[nb] = bit'((val >> (msb ? (n - 1 - i) : i)) & 1); nb++;
    end
    ones = $countones(val & ((1 << n) - 1));
    if (par != 0) begin
      case (par)
        1: p = ones & 1;
        2: p = (ones & 1) ^ 1;
        3: p = 0;
        default: p = 1;
      endcase
      if (bad != 0) p = p ^ 1;
      bits[nb] = bit'(p); nb++;
    end
    bits[nb] = 1'b1; nb++;
    total = (nb * 65536) / inc;
    for (int c = 0; c < total; c++) begin
      int k, ks;
      logic v;
      k = (c * inc) / 65536;
      ks = (k * 65536 + inc - 1) / inc;
      v = bits[k];
      if (k == gbit && (c - ks) >= 12 && (c - ks) <= 18) v = ~v;
      @(negedge clk);
      lines[ln] = v;
    end
    @(negedge clk);
    lines[ln] = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(2'd0, v); check("R1 config", v, 0);
    rd(2'd1, v); check("R1 step", v, 16'h4B00);
    rd(2'd2, v); check("R1 flags", v, 0);
    rd(2'd3, v); check("R1 word", v, 0);
    check("R1 irq", int'(irq), 0);

    // R13: stored bits read back
    wr(2'd0, 16'h6000);
    rd(2'd0, v); check("R13 readback", v, 16'h6000);

    // R12: disabled block ignores a frame
    wr(2'd1, 16'h0800);
    send_frame(0, 8'h5A, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd2, v); check("R12 disabled flags", v, 0);
    rd(2'd3, v); check("R12 disabled word", v, 0);

    // R3 R4 R5 sweep over parity, width and order, plus R13 bits set
    for (int par = 0; par < 5; par++) begin
      for (int nine = 0; nine < 2; nine++) begin
        for (int msb = 0; msb < 2; msb++) begin
          wr(2'd0, mk_cfg(1, 0, par, nine, msb, 0, 0) | 16'h6000);
          for (int k = 0; k < 4; k++) begin
            int val, mask;
            mask = nine ? 'h1FF : 'hFF;
            val = (k == 0) ? 0 : (k == 1) ? 'h1FF : (k == 2) ? ('h0B4 + par * 7) : ('h13A ^ (msb << 4) ^ nine);
            val = val & mask;
            wr(2'd2, 16'h7);
            send_frame(0, val, nine, msb, par, 0, 16'h0800, -1);
            rd(2'd3, v); check("R3 R4 word", v, val);
            rd(2'd2, v); check("R5 good parity flags", v, 1);
          end
          if (par != 0) begin
            wr(2'd2, 16'h7);
            send_frame(0, 'h0C3 & (nine ? 'h1FF : 'hFF), nine, msb, par, 1, 16'h0800, -1);
            rd(2'd2, v); check("R5 bad parity flags", v, 3);
          end
        end
      end
    end

    // R2: other step values
    for (int s = 0; s < 3; s++) begin
      int inc;
      inc = (s == 0) ? 16'h0400 : (s == 1) ? 16'h0C00 : 16'h0800;
      wr(2'd1, 16'(inc));
      wr(2'd0, mk_cfg(1, 0, 1, 0, 0, 0, 0));
      wr(2'd2, 16'h7);
      send_frame(0, 'h96 + s, 0, 0, 1, 0, inc, -1);
      rd(2'd3, v); check("R2 word at step", v, 'h96 + s);
      rd(2'd2, v); check("R2 flags at step", v, 1);
    end
    wr(2'd1, 16'h0800);

    // R6: line select
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 2, 0));
    wr(2'd2, 16'h7);
    send_frame(1, 'h33, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd2, v); check("R6 other line ignored", v, 0);
    send_frame(2, 'h44, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd2, v); check("R6 selected line flags", v, 1);
    rd(2'd3, v); check("R6 selected line word", v, 'h44);

    // R7: 7-clock glitch in data bit 2; filter depth 1 lets it through, depth 8 removes it
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 0));
    wr(2'd2, 16'h7);
    send_frame(0, 'h00, 0, 0, 0, 0, 16'h0800, 3);
    rd(2'd3, v); check("R7 unfiltered glitch", v, 'h04);
    wr(2'd0, mk_cfg(1, 3, 0, 0, 0, 0, 0));
    wr(2'd2, 16'h7);
    send_frame(0, 'h00, 0, 0, 0, 0, 16'h0800, 3);
    rd(2'd3, v); check("R7 filtered glitch", v, 'h00);
    send_frame(0, 'hE1, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd3, v); check("R7 deep filter frame", v, 'hE1);

    // R8: short low pulse is a false start
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 0));
    wr(2'd2, 16'h7);
    @(negedge clk); lines[0] = 1'b0;
    repeat (3) @(negedge clk); lines[0] = 1'b1;
    repeat (400) @(negedge clk);
    rd(2'd2, v); check("R8 false start flags", v, 0);
    send_frame(0, 'h7E, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd3, v); check("R8 frame after false start", v, 'h7E);

    // R10: overrun
    wr(2'd2, 16'h7);
    send_frame(0, 'h11, 0, 0, 0, 0, 16'h0800, -1);
    send_frame(0, 'h22, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd2, v); check("R10 overrun flags", v, 5);
    rd(2'd3, v); check("R10 overwritten word", v, 'h22);

    // R11: interrupt masking
    check("R11 no enables", int'(irq), 0);
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 2));
    check("R11 pe enable only", int'(irq), 0);
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 4));
    check("R11 ov enable", int'(irq), 1);
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 1));
    check("R11 rx enable", int'(irq), 1);

    // R9: write-one-to-clear, one bit at a time
    wr(2'd2, 16'h2);
    rd(2'd2, v); check("R9 clear absent bit", v, 5);
    wr(2'd2, 16'h4);
    rd(2'd2, v); check("R9 clear ov", v, 1);
    check("R11 irq with rx", int'(irq), 1);
    wr(2'd2, 16'h1);
    rd(2'd2, v); check("R9 clear rx", v, 0);
    check("R11 irq cleared", int'(irq), 0);

    // R12: disable mid-frame, registers kept
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 0));
    fork
      send_frame(0, 'h5C, 0, 0, 0, 0, 16'h0800, -1);
      begin
        repeat (100) @(negedge clk);
        wr(2'd0, mk_cfg(0, 0, 0, 0, 0, 0, 0));
      end
    join
    rd(2'd2, v); check("R12 aborted frame flags", v, 0);
    rd(2'd3, v); check("R12 word kept", v, 'h22);
    rd(2'd1, w); check("R12 step kept", w, 16'h0800);
    wr(2'd0, mk_cfg(1, 0, 0, 0, 0, 0, 0));
    send_frame(0, 'h5C, 0, 0, 0, 0, 16'h0800, -1);
    rd(2'd3, v); check("R12 after re-enable", v, 'h5C);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule